// File: doc/BRIEF.md
# Accumulator Processor Datapath

This block is the data-handling half of a small accumulator machine. It holds an 8-bit accumulator, an 8-bit instruction register, a 5-bit program counter with its incrementer, an 8-bit adder/subtractor, and a 32-entry by 8-bit memory that stores both program and data. An external sequencer drives one control word per clock. The datapath reports back the 3-bit opcode field of the held instruction, plus two status lines taken directly from the accumulator: one says the accumulator is zero, the other says it is non-negative.

The memory address comes from one of two places. During instruction fetch it is the program counter. For an operand, or for a jump target, it is the low 5 bits of the instruction register. Memory reads are synchronous. Read data is captured at a clock edge and is used in the cycle after that edge. A reset clears every register. The memory contents are not cleared by reset, so a program is placed in memory through the normal write path.

Top module: `acc_datapath`

## Requirements
- R1: While reset (active high, asynchronous) is asserted and after it is released, the accumulator, instruction register, program counter and read data register are zero. So `acc_out`=0, `opcode`=0, `acc_zero`=1 and `acc_pos`=1 until a load occurs.
- R2: When `ctl_mem_operand`=0 the memory address is the program counter. When it is 1 the address is bits [4:0] of the instruction register. At each clock edge the read data register captures the addressed word as it was before any write made at that same edge.
- R3: When `ctl_mem_write`=1, the accumulator value is written to the selected address at the clock edge.
- R4: When `ctl_pc_load`=1 and `ctl_jump_sel`=0, the program counter becomes (PC+1) mod 32, so 31 wraps to 0. When `ctl_pc_load`=1 and `ctl_jump_sel`=1, it becomes instruction register bits [4:0]. When `ctl_pc_load`=0, it holds its value.
- R5: When `ctl_ir_load`=1, the instruction register takes the read data register value. `opcode` is instruction register bits [7:5]. The instruction register holds when `ctl_ir_load`=0.
- R6: When `ctl_acc_load`=1, the accumulator takes the value selected by `ctl_acc_src`: 00 selects the adder/subtractor result, 01 selects `ext_in`, 10 selects the read data register, and 11 behaves the same as 00. When `ctl_acc_load`=0, the accumulator holds whatever the other inputs do.
- R7: The adder/subtractor produces (A + D) mod 256 when `ctl_subtract`=0 and (A − D) mod 256 when `ctl_subtract`=1, where D is the read data register value.
- R8: `acc_zero` is 1 exactly when all accumulator bits are 0. `acc_pos` is the inverse of accumulator bit 7. Both follow the accumulator in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| ctl_ir_load | input | 1 | Load instruction register from read data |
| ctl_jump_sel | input | 1 | Next-PC select: 0 increment, 1 instruction address field |
| ctl_pc_load | input | 1 | Program counter load enable |
| ctl_mem_operand | input | 1 | Memory address select: 0 PC, 1 instruction address field |
| ctl_mem_write | input | 1 | Write accumulator to the selected address |
| ctl_acc_src | input | 2 | Accumulator source select |
| ctl_acc_load | input | 1 | Accumulator load enable |
| ctl_subtract | input | 1 | 1 subtracts, 0 adds |
| ext_in | input | 8 | External data input |
| opcode | output | 3 | Top 3 bits of instruction register |
| acc_zero | output | 1 | Accumulator equals zero |
| acc_pos | output | 1 | Accumulator bit 7 is clear |
| acc_out | output | 8 | Accumulator value |

## Verification
Loads into the accumulator, the instruction register and the program counter appear one clock after the edge that applies them. The status lines change in that same cycle. A value read from memory takes one edge to reach the read data register and a second edge to reach the accumulator or instruction register, so it is visible two cycles after its address is presented. The bench drives each control word on a falling edge and advances its own requirement-level model on the rising edge. It compares the outputs at the next falling edge, so every check samples exactly the cycle in which a result is due. The program counter has no port of its own. Its effects are checked through the data it addresses.

// File: rtl/accdp_pkg.sv
package accdp_pkg;

   typedef enum logic [1:0] {
      ACC_FROM_ALU = 2'b00,
      ACC_FROM_EXT = 2'b01,
      ACC_FROM_MEM = 2'b10,
      ACC_SPARE    = 2'b11
   } acc_src_e;

endpackage

// File: rtl/dp_reg.sv
module dp_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin : chk_w
      assert (W >= 1) else $error("dp_reg: W must be at least 1");
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)
         q <= '0;
      else if (ld)
         q <= d;
   end

endmodule

// File: rtl/dp_addsub.sv
module dp_addsub #(
   parameter int W         = 8,
   parameter bit INVERT_IN = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] y
);

   initial begin : chk_w
      assert (W >= 2) else $error("dp_addsub: W must be at least 2");
   end

   generate
      if (INVERT_IN) begin : g_invert
         // single adder: a + (b ^ sub) + sub
         logic [W-1:0] b_eff;
         always_comb begin
            b_eff = sub ? ~b : b;
            y     = a + b_eff + W'(sub);
         end
      end else begin : g_dual
         always_comb begin
            y = sub ? (a - b) : (a + b);
         end
      end
   endgenerate

endmodule

// File: rtl/dp_sync_mem.sv
module dp_sync_mem #(
   parameter int AW = 5,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] addr,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   initial begin : chk_size
      assert (AW >= 1 && AW <= 10) else $error("dp_sync_mem: AW out of range");
   end

   logic [DW-1:0] store [DEPTH];

   // array has no reset; content comes only through writes
   always_ff @(posedge clk) begin
      if (we)
         store[addr] <= wdata;
   end

   // read-before-write capture of the addressed word
   always_ff @(posedge clk or posedge rst) begin
      if (rst)
         rdata <= '0;
      else
         rdata <= store[addr];
   end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 5,
   parameter int OPC_W       = 3,
   parameter bit ALU_INVERT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ctl_ir_load,
   input  logic              ctl_jump_sel,
   input  logic              ctl_pc_load,
   input  logic              ctl_mem_operand,
   input  logic              ctl_mem_write,
   input  logic [1:0]        ctl_acc_src,
   input  logic              ctl_acc_load,
   input  logic              ctl_subtract,
   input  logic [DATA_W-1:0] ext_in,
   output logic [OPC_W-1:0]  opcode,
   output logic              acc_zero,
   output logic              acc_pos,
   output logic [DATA_W-1:0] acc_out
);
   import accdp_pkg::*;

   localparam int OPC_LSB = DATA_W - OPC_W;

   initial begin : chk_fields
      assert (OPC_W + ADDR_W == DATA_W)
         else $error("acc_datapath: opcode and address fields must fill the word");
      assert (OPC_W >= 1 && ADDR_W >= 1)
         else $error("acc_datapath: empty field");
   end

   logic [DATA_W-1:0] acc_q, ir_q, rd_q, alu_y, acc_d;
   logic [ADDR_W-1:0] pc_q, pc_inc, pc_d, mem_addr, ir_addr;
   acc_src_e          src;

   assign ir_addr = ir_q[ADDR_W-1:0];
   assign pc_inc  = pc_q + ADDR_W'(1);
   assign src     = acc_src_e'(ctl_acc_src);

   // next program counter select
   always_comb begin
      pc_d = ctl_jump_sel ? ir_addr : pc_inc;
   end

   // memory address select
   always_comb begin
      mem_addr = ctl_mem_operand ? ir_addr : pc_q;
   end

   // accumulator input select; spare code falls back to the ALU
   always_comb begin
      unique case (src)
         ACC_FROM_EXT: acc_d = ext_in;
         ACC_FROM_MEM: acc_d = rd_q;
         ACC_FROM_ALU,
         ACC_SPARE:    acc_d = alu_y;
         default:      acc_d = alu_y;
      endcase
   end

   dp_addsub #(.W(DATA_W), .INVERT_IN(ALU_INVERT)) u_alu (
      .a   (acc_q),
      .b   (rd_q),
      .sub (ctl_subtract),
      .y   (alu_y)
   );

   dp_sync_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
      .clk   (clk),
      .rst   (rst),
      .addr  (mem_addr),
      .we    (ctl_mem_write),
      .wdata (acc_q),
      .rdata (rd_q)
   );

   dp_reg #(.W(DATA_W)) u_acc (
      .clk (clk), .rst (rst), .ld (ctl_acc_load), .d (acc_d), .q (acc_q)
   );

   dp_reg #(.W(DATA_W)) u_ir (
      .clk (clk), .rst (rst), .ld (ctl_ir_load), .d (rd_q), .q (ir_q)
   );

   dp_reg #(.W(ADDR_W)) u_pc (
      .clk (clk), .rst (rst), .ld (ctl_pc_load), .d (pc_d), .q (pc_q)
   );

   assign opcode   = ir_q[DATA_W-1:OPC_LSB];
   assign acc_zero = ~|acc_q;
   assign acc_pos  = ~acc_q[DATA_W-1];
   assign acc_out  = acc_q;

endmodule

// File: rtl/acc_datapath_chk.sv
module acc_datapath_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 5,
   parameter int OPC_W  = 3
) (
   input logic              clk,
   input logic              rst,
   input logic              ctl_ir_load,
   input logic              ctl_jump_sel,
   input logic              ctl_pc_load,
   input logic [1:0]        ctl_acc_src,
   input logic              ctl_acc_load,
   input logic              ctl_subtract,
   input logic [DATA_W-1:0] ext_in,
   input logic [OPC_W-1:0]  opcode,
   input logic              acc_zero,
   input logic              acc_pos,
   input logic [DATA_W-1:0] acc_out,
   input logic [ADDR_W-1:0] pc_q,
   input logic [DATA_W-1:0] ir_q,
   input logic [DATA_W-1:0] rd_q
);

   // R1: registers are zero while reset is held
   always @(negedge clk) begin
      if (rst) begin
         p_reset_clear_r1: assert (acc_out == '0 && pc_q == '0 && ir_q == '0)
            else $error("reset did not clear registers");
      end
   end

   p_pc_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !ctl_pc_load |=> $stable(pc_q));

   p_pc_step_r4: assert property (@(posedge clk) disable iff (rst)
      (ctl_pc_load && !ctl_jump_sel) |=> pc_q == $past(pc_q) + ADDR_W'(1));

   p_pc_jump_r4: assert property (@(posedge clk) disable iff (rst)
      (ctl_pc_load && ctl_jump_sel) |=> pc_q == $past(ir_q[ADDR_W-1:0]));

   p_ir_take_r5: assert property (@(posedge clk) disable iff (rst)
      ctl_ir_load |=> opcode == $past(rd_q[DATA_W-1:DATA_W-OPC_W]));

   p_ir_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !ctl_ir_load |=> $stable(opcode));

   p_acc_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !ctl_acc_load |=> $stable(acc_out));

   p_acc_ext_r6: assert property (@(posedge clk) disable iff (rst)
      (ctl_acc_load && ctl_acc_src == 2'b01) |=> acc_out == $past(ext_in));

   p_acc_mem_r6: assert property (@(posedge clk) disable iff (rst)
      (ctl_acc_load && ctl_acc_src == 2'b10) |=> acc_out == $past(rd_q));

   p_acc_add_r7: assert property (@(posedge clk) disable iff (rst)
      (ctl_acc_load && ctl_acc_src[1] == ctl_acc_src[0] && !ctl_subtract)
      |=> acc_out == $past(acc_out) + $past(rd_q));

   p_acc_sub_r7: assert property (@(posedge clk) disable iff (rst)
      (ctl_acc_load && ctl_acc_src[1] == ctl_acc_src[0] && ctl_subtract)
      |=> acc_out == $past(acc_out) - $past(rd_q));

   p_flag_order_r8: assert property (@(posedge clk) disable iff (rst)
      acc_zero |-> acc_pos);

endmodule

bind acc_datapath acc_datapath_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .OPC_W  (OPC_W)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .ctl_ir_load  (ctl_ir_load),
   .ctl_jump_sel (ctl_jump_sel),
   .ctl_pc_load  (ctl_pc_load),
   .ctl_acc_src  (ctl_acc_src),
   .ctl_acc_load (ctl_acc_load),
   .ctl_subtract (ctl_subtract),
   .ext_in       (ext_in),
   .opcode       (opcode),
   .acc_zero     (acc_zero),
   .acc_pos      (acc_pos),
   .acc_out      (acc_out),
   .pc_q         (pc_q),
   .ir_q         (ir_q),
   .rd_q         (rd_q)
);

// File: tb/acc_datapath_tb_top.sv
module acc_datapath_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ctl_ir_load = 0, ctl_jump_sel = 0, ctl_pc_load = 0;
   logic       ctl_mem_operand = 0, ctl_mem_write = 0;
   logic [1:0] ctl_acc_src = 2'b00;
   logic       ctl_acc_load = 0, ctl_subtract = 0;
   logic [7:0] ext_in = 8'h00;
   logic [2:0] opcode;
   logic       acc_zero, acc_pos;
   logic [7:0] acc_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   // requirement-level model state
   logic [7:0] m_mem [32];
   logic [7:0] m_a = 0, m_ir = 0, m_rd = 0;
   logic [4:0] m_pc = 0;

   always #2 clk = ~clk;   // 250 MHz

   acc_datapath dut_i (
      .clk             (clk),
      .rst             (rst),
      .ctl_ir_load     (ctl_ir_load),
      .ctl_jump_sel    (ctl_jump_sel),
      .ctl_pc_load     (ctl_pc_load),
      .ctl_mem_operand (ctl_mem_operand),
      .ctl_mem_write   (ctl_mem_write),
      .ctl_acc_src     (ctl_acc_src),
      .ctl_acc_load    (ctl_acc_load),
      .ctl_subtract    (ctl_subtract),
      .ext_in          (ext_in),
      .opcode          (opcode),
      .acc_zero        (acc_zero),
      .acc_pos         (acc_pos),
      .acc_out         (acc_out)
   );

   function automatic logic [7:0] exp_alu(input logic [7:0] a, input logic [7:0] d,
                                          input logic s);
      return s ? 8'(a - d) : 8'(a + d);
   endfunction

   task automatic cmp8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      cmp8({tag, " acc"}, acc_out, m_a);
      cmp8("R5 opcode", {5'd0, opcode}, {5'd0, m_ir[7:5]});
      cmp8("R8 zero", {7'd0, acc_zero}, {7'd0, (m_a == 8'h00)});
      cmp8("R8 pos", {7'd0, acc_pos}, {7'd0, ~m_a[7]});
   endtask

   // drive at falling edge, model at rising edge, compare at next falling edge
   task automatic step(input logic irl, input logic jmp, input logic pcl,
                       input logic opd, input logic wr, input logic [1:0] src,
                       input logic al, input logic sb, input logic [7:0] ext,
                       input string tag);
      logic [4:0] addr;
      logic [7:0] rd_n;
      ctl_ir_load = irl; ctl_jump_sel = jmp; ctl_pc_load = pcl;
      ctl_mem_operand = opd; ctl_mem_write = wr; ctl_acc_src = src;
      ctl_acc_load = al; ctl_subtract = sb; ext_in = ext;
      @(posedge clk);
      addr = opd ? m_ir[4:0] : m_pc;
      rd_n = m_mem[addr];
      if (wr) m_mem[addr] = m_a;
      if (pcl) m_pc = jmp ? m_ir[4:0] : 5'(m_pc + 5'd1);
      if (al) begin
         case (src)
            2'b01:   m_a = ext;
            2'b10:   m_a = m_rd;
            default: m_a = exp_alu(m_a, m_rd, sb);
         endcase
      end
      if (irl) m_ir = m_rd;
      m_rd = rd_n;
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle(input logic opd, input string tag);
      step(0, 0, 0, opd, 0, 2'b00, 0, 0, 8'h00, tag);
   endtask

   initial begin : watchdog
      #(200000 * 4);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd20417));
      for (int i = 0; i < 32; i++) m_mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R1 check while reset held
      cmp8("R1 acc in reset", acc_out, 8'h00);
      rst = 1'b0;
      @(negedge clk);
      cmp8("R1 acc", acc_out, 8'h00);
      cmp8("R1 opcode", {5'd0, opcode}, 8'h00);
      cmp8("R1 zero", {7'd0, acc_zero}, 8'h01);
      cmp8("R1 pos", {7'd0, acc_pos}, 8'h01);

      // fill memory through the PC address path; PC wraps 31 -> 0 (R3, R4)
      for (int i = 0; i < 32; i++) begin
         logic [7:0] v;
         v = 8'($urandom);
         step(0, 0, 0, 0, 0, 2'b01, 1, 0, v, "R6 fill ext");
         step(0, 0, 1, 0, 1, 2'b00, 0, 0, 8'h00, "R3 fill store");
      end

      // fetch through PC after wrap (R2, R4, R5)
      idle(0, "R2 pc read");
      step(1, 0, 0, 0, 0, 2'b00, 0, 0, 8'h00, "R5 ir load");
      step(0, 1, 1, 0, 0, 2'b00, 0, 0, 8'h00, "R4 jump");
      idle(0, "R2 read at jump target");
      step(0, 0, 0, 0, 0, 2'b10, 1, 0, 8'h00, "R4 target word to acc");
      idle(1, "R2 operand read");
      step(0, 0, 0, 1, 0, 2'b10, 1, 0, 8'h00, "R2 operand to acc");

      // flags at boundary values (R8)
      step(0, 0, 0, 0, 0, 2'b01, 1, 0, 8'h00, "R8 zero value");
      step(0, 0, 0, 0, 0, 2'b01, 1, 0, 8'h80, "R8 min negative");
      step(0, 0, 0, 0, 0, 2'b01, 1, 0, 8'h7F, "R8 max positive");

      // store 1 at operand address, then 7F+1 and 00-1 (R3, R7)
      step(0, 0, 0, 0, 0, 2'b01, 1, 0, 8'h01, "R6 ext");
      step(0, 0, 0, 1, 1, 2'b00, 0, 0, 8'h00, "R3 operand store");
      step(0, 0, 0, 0, 0, 2'b01, 1, 0, 8'h7F, "R6 ext");
      idle(1, "R2 operand read back");
      step(0, 0, 0, 1, 0, 2'b00, 1, 0, 8'h00, "R7 add overflow");
      step(0, 0, 0, 0, 0, 2'b01, 1, 0, 8'h00, "R6 ext");
      idle(1, "R2 operand read back");
      step(0, 0, 0, 1, 0, 2'b00, 1, 1, 8'h00, "R7 sub underflow");
      step(0, 0, 0, 1, 0, 2'b11, 1, 0, 8'h00, "R6 spare code adds");
      // hold: ext changes, load low (R6)
      step(0, 0, 0, 1, 0, 2'b01, 0, 0, 8'h5A, "R6 hold");
      step(0, 0, 0, 1, 0, 2'b10, 0, 1, 8'hA5, "R6 hold");

      // constrained random control words
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] r;
         r = 8'($urandom);
         step(r[0], r[1], r[2], r[3], (r[7:6] == 2'b11), 2'($urandom),
              r[4], r[5], 8'($urandom), "R2/R3/R4/R6/R7 random");
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule